// File: doc/BRIEF.md
# Periodic Millisecond Interrupt Timer

This block produces a repeating interrupt at a programmable millisecond interval. It divides its input clock down to a one-millisecond tick and feeds that tick to a counter. The counter advances only while counting is enabled. When the counter would reach the programmed period, it restarts from zero and raises a sticky match flag. The interrupt output is the match flag gated by a separate interrupt enable. A rate of f Hz is set by writing the period 1000/f, so the supported rates run from 1 Hz (period 1000) to 1000 Hz (period 1).

Software reaches the block through a plain single-cycle write strobe with an address and write data. A read-data bus decodes the same address combinationally. There are three registers: a control/status word, the live millisecond counter and the period. The counter can be written directly, for example to preload a phase. A write to the period leaves the counter untouched.

Top module: `ms_period_timer`

## Requirements
- R1: After reset the counter, the period, both enables and the match flag are all zero, and `irq` is low.
- R2: The control/status word is at address 0x08, with bit 15 as count enable, bit 14 as interrupt enable and bit 13 as the match flag; all its other bits read 0. The counter reads and writes at 0x34 and the period at 0x38, both zero-extended on read. Any other address reads 0.
- R3: While count enable is high, the counter advances by one every CLK_HZ/1000 clock cycles. The first advance comes CLK_HZ/1000 cycles after the write that sets the enable.
- R4: When the counter would advance to a value equal to a non-zero period P, it becomes 0 instead and the match flag is set. A counter preloaded to S below P therefore reads (S+t) mod P after t ticks, and the flag is set once S+t reaches P. P=1 matches on every tick.
- R5: A period of 0 never produces a match: the counter keeps advancing and the flag stays clear.
- R6: `irq` is high exactly when the match flag and the interrupt enable are both set.
- R7: Writing 1 to bit 13 of the control/status word clears the match flag. Writing 0 there leaves the flag unchanged.
- R8: A write to the counter loads it and restarts the millisecond divider. A write to the period leaves the counter value unchanged.
- R9: While count enable is low, the counter holds its value. Clearing both enables together stops counting and keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Periodic interrupt request |

## Verification
The in-line assertions check, on every cycle, that the counter holds while disabled and not written, that a period of zero never raises the flag, that a newly raised flag leaves the counter at zero, and that the flag falls only in the cycle after a write-one-to-clear. Only the bench scenarios can show the actual tick spacing of CLK_HZ/1000 cycles, the modular count sequence against a preloaded phase, and the 1 Hz and 1000 Hz extremes of the period. They also show that the interrupt follows its enable and that a period write preserves the count.

// File: rtl/ms_period_timer.sv
module ms_period_timer #(
  parameter int CLK_HZ = 50_000_000,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] CNT_ADDR  = 8'h34,
  parameter logic [ADDR_W-1:0] PER_ADDR  = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int DIV   = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 1;
  localparam int PRE_W = $clog2(DIV + 1);
  localparam int CE_B  = 15;
  localparam int IE_B  = 14;
  localparam int FL_B  = 13;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, period;
  logic             cnt_en, irq_en, flag;

  wire wr_stat = wr_en && addr == STAT_ADDR;
  wire wr_cnt  = wr_en && addr == CNT_ADDR;
  wire wr_per  = wr_en && addr == PER_ADDR;

  wire             tick    = cnt_en && pre == PRE_W'(DIV - 1);
  wire [CNT_W-1:0] cnt_inc = cnt + 1'b1;
  wire             match   = tick && period != '0 && cnt_inc == period;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       pre <= '0;
    else if (wr_cnt || !cnt_en || tick) pre <= '0;
    else                              pre <= pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= wdata[CNT_W-1:0];
    else if (match)  cnt <= '0;
    else if (tick)   cnt <= cnt_inc;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      period <= '0;
    else if (wr_per) period <= wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr_stat) begin
      cnt_en <= wdata[CE_B];
      irq_en <= wdata[IE_B];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      flag <= 1'b0;
    else if (match)                  flag <= 1'b1;
    else if (wr_stat && wdata[FL_B]) flag <= 1'b0;

  always_comb begin
    rdata = '0;
    if (addr == STAT_ADDR) begin
      rdata[CE_B] = cnt_en;
      rdata[IE_B] = irq_en;
      rdata[FL_B] = flag;
    end else if (addr == CNT_ADDR) rdata[CNT_W-1:0] = cnt;
    else if (addr == PER_ADDR)     rdata[CNT_W-1:0] = period;
  end

  assign irq = flag & irq_en;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_cnt) |=> $stable(cnt));

  p_zero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> !$rose(flag));

  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && !$past(wr_cnt)) |-> cnt == '0);

  p_w1c_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_stat && wdata[FL_B]));
endmodule

// File: tb/ms_period_timer_test.sv
module ms_period_timer_test;
  localparam int DIV = 8;
  localparam logic [7:0] A_ST = 8'h08, A_CN = 8'h34, A_PE = 8'h38;
  localparam logic [31:0] CE = 32'h8000, IE = 32'h4000, FL = 32'h2000;

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  int n_tests = 0, n_fail = 0;

  ms_period_timer #(.CLK_HZ(DIV * 1000)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int exp_cnt(int s, int t, int p);
    return (p == 0) ? s + t : (s + t) % p;
  endfunction
  function automatic bit exp_flag(int s, int t, int p);
    return p != 0 && s + t >= p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic waitc(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setup(int p, int s, logic [31:0] en);
    wr(A_ST, FL);
    wr(A_PE, p);
    wr(A_CN, s);
    wr(A_ST, en);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_ST, v); chk("R1 status", v, 0);
    rd(A_CN, v); chk("R1 counter", v, 0);
    rd(A_PE, v); chk("R1 period", v, 0);
    chk("R1 irq", irq, 0);
    rd(8'h20, v); chk("R2 unmapped", v, 0);

    setup(100, 0, CE);
    waitc(DIV - 1); rd(A_CN, v); chk("R3 before first tick", v, 0);
    waitc(1); rd(A_CN, v); chk("R3 first tick", v, 1);
    rd(A_ST, v); chk("R2 status bits", v, CE);

    setup(1, 0, CE | IE);
    waitc(DIV); rd(A_ST, v); chk("R4 period 1 flag", v, CE | IE | FL);
    rd(A_CN, v); chk("R4 period 1 count", v, 0);
    chk("R6 irq with enable", irq, 1);
    wr(A_ST, CE); chk("R6 irq gated off", irq, 0);
    wr(A_ST, CE | IE); chk("R7 write 0 keeps flag", irq, 1);

    setup(1000, 0, CE | IE);
    waitc(DIV * 1000 - 1); chk("R4 1 Hz not yet", irq, 0);
    waitc(1); chk("R4 1 Hz match", irq, 1);
    rd(A_CN, v); chk("R4 1 Hz wrap", v, 0);

    wr(A_ST, FL);
    rd(A_ST, v); chk("R9 both enables off", v, 0);
    wr(A_CN, 5);
    waitc(DIV * 6); rd(A_CN, v); chk("R9 hold", v, 5);
    chk("R9 irq low", irq, 0);
    wr(A_PE, 9); rd(A_CN, v); chk("R8 period write keeps count", v, 5);
    rd(A_PE, v); chk("R2 period readback", v, 9);

    setup(0, 3, CE | IE);
    waitc(DIV * 20); rd(A_CN, v); chk("R5 zero period count", v, 23);
    rd(A_ST, v); chk("R5 zero period flag", v[13], 0);

    for (int i = 0; i < 25; i++) begin
      int p, s, k, t;
      logic [31:0] en;
      p = ($urandom % 8 == 0) ? 0 : 1 + $urandom % 20;
      s = (p == 0) ? $urandom % 50 : $urandom % p;
      k = $urandom % (DIV * 45);
      en = CE | (($urandom % 2) ? IE : 32'h0);
      t = k / DIV;
      setup(p, s, en);
      waitc(k);
      rd(A_CN, v); chk("R4 random count", v, exp_cnt(s, t, p));
      rd(A_ST, v); chk("R7 random flag", v[13], exp_flag(s, t, p));
      chk("R6 random irq", irq, exp_flag(s, t, p) && en[14]);
    end

    wr(A_ST, FL);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule